// File: doc/BRIEF.md
# Fault Status Register with Clearing Handshake

This block holds the fault status word of a timer's protection logic. Up to four
pre-filtered fault lines come in, each gated by its own enable and by one global
fault-control enable. Each gated line that goes high sets a sticky flag. A summary
bit reports whether any sticky flag is set. A live bit shows the current OR of the
enabled lines. The same block keeps the write-protect enable that guards
configuration registers elsewhere, and drives it out on `wp_en`.

Software sees two word addresses on a simple synchronous register port. The status
word sits at `STATUS_ADDR`. The control word at `CTRL_ADDR` carries only the
write-protect-disable bit at position `WPD_BIT`. Read data is combinational and is
valid in the cycle of `rd_en`. A write takes effect at the clock edge of the cycle
in which `wr_en` is high. The port has no back-pressure: every access completes in
one cycle, so no valid/ready handshake exists.

A sticky flag can only be cleared by a two-step handshake. First, a status read must
see the flag at 1. Then a write of 0 to that flag must arrive while its fault is
absent. A fault between the two steps cancels the handshake.

Top module: `fault_status_reg`

## Requirements
- R1: After reset every sticky flag and the write-protect enable are 0, so a status read returns 0.
- R2: Flag i (status bit i, for i = 0..3) is set at the clock edge of a cycle in which `fault_ctl_en`, `fault_in_en[i]` and `fault_in[i]` are all 1. If either enable is 0, the line sets nothing.
- R3: Flag i clears only on a status write with data bit i = 0 that follows a status read which saw flag i at 1. Its fault must be absent in the write cycle. A write of 1 to a flag bit, or a write of 0 with no arming read before it, leaves the flag unchanged.
- R4: If flag i's fault is detected after the arming read, the handshake is cancelled: the next clearing write has no effect. A fresh read then re-arms the flag.
- R5: Every status write disarms every flag and the summary bit, whether or not anything cleared. A second write after a single read clears nothing.
- R6: A fault detected in the same cycle as a clearing write wins, and the flag stays 1.
- R7: Status bit 7 is the OR of the flags. A status write with bit 7 = 0 clears all flags at once, provided two conditions hold: a status read saw bit 7 at 1 beforehand, and no enabled fault line has shown a fault since that read, including the write cycle.
- R8: Status bit 5 reads the OR of the enabled fault lines while `fault_ctl_en` is 1, and 0 while it is 0. Writes do not change it.
- R9: Status bits 31..8 and bit 4 always read 0, and writing 1s to them has no effect.
- R10: Writing 1 to status bit 6 sets the write-protect enable (`wp_en` and read bit 6). Writing 0 to bit 6 has no effect.
- R11: The write-protect enable clears only when a status read has seen it at 1 and a later control write carries 1 in bit `WPD_BIT` (bit 2 by default). Any control write disarms this sequence, and a write of 0 there does nothing. Reading the control word returns the inverse of the write-protect enable in bit `WPD_BIT`, with all other bits 0.
- R12: `rdata` is 0 in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_ctl_en | input | 1 | Global fault-control enable |
| fault_in_en | input | NUM_FAULT | Per-line fault enable |
| fault_in | input | NUM_FAULT | Filtered fault lines, active high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational during rd_en |
| wp_en | output | 1 | Write-protect enable for guarded registers |

## Verification
The bench uses the default parameters: four fault lines, a 4-bit address with status at 0 and control at 1, the disable bit at position 2, and 32-bit data. With these values every flag position, the reserved bit between the flags and the live bit, and both register addresses are reachable. The vectors place faults before the arming read, between read and write, and in the write cycle itself. They also cover writes of 1s to the flag and reserved bits, and the summary clear with a line still faulty. The write-protect sequence is driven with and without its arming read, and with a zero written to the disable bit.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  // Bit positions inside the status word; software decodes these.
  localparam int unsigned SUM_POS  = 7;
  localparam int unsigned WP_POS   = 6;
  localparam int unsigned LIVE_POS = 5;
  localparam int unsigned MAX_FAULT = 4;

  typedef struct packed {
    logic rd_stat;
    logic wr_stat;
    logic rd_ctl;
    logic wr_ctl;
  } acc_t;
endpackage

// File: rtl/fsr_flag_cell.sv
module fsr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic det,       // gated fault seen this cycle
  input  logic rd_stat,   // status read strobe
  input  logic wr_stat,   // status write strobe
  input  logic wbit,      // write data for this flag
  input  logic sum_clr,   // summary clear request
  output logic flag_o
);
  logic flag_q, arm_q;
  logic own_clr;

  assign own_clr = arm_q & wr_stat & ~wbit & ~det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      // detection has priority over any clearing path
      if (det)                       flag_q <= 1'b1;
      else if (own_clr || sum_clr)   flag_q <= 1'b0;

      if (det)          arm_q <= 1'b0;
      else if (wr_stat) arm_q <= 1'b0;
      else if (rd_stat) arm_q <= flag_q;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/fsr_sum_ctl.sv
module fsr_sum_ctl #(
  parameter int unsigned NUM_FAULT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FAULT-1:0] det,
  input  logic [NUM_FAULT-1:0] flags,
  input  logic                 rd_stat,
  input  logic                 wr_stat,
  input  logic                 wbit,
  output logic                 sum_clr
);
  logic arm_q;
  logic any_det;

  assign any_det = |det;
  assign sum_clr = arm_q & wr_stat & ~wbit & ~any_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm_q <= 1'b0;
    else if (any_det) arm_q <= 1'b0;
    else if (wr_stat) arm_q <= 1'b0;
    else if (rd_stat) arm_q <= |flags;
  end
endmodule

// File: rtl/fsr_wp_latch.sv
module fsr_wp_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stat,
  input  logic wr_stat,
  input  logic set_bit,   // status write data, protect bit
  input  logic wr_ctl,
  input  logic dis_bit,   // control write data, disable bit
  output logic wp_o
);
  logic wp_q, arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (wr_stat && set_bit)             wp_q <= 1'b1;
      else if (wr_ctl && dis_bit && arm_q) wp_q <= 1'b0;

      if (wr_ctl)                 arm_q <= 1'b0;
      else if (rd_stat && wp_q)   arm_q <= 1'b1;
    end
  end

  assign wp_o = wp_q;
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
  parameter int unsigned NUM_FAULT   = 4,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STATUS_ADDR = 0,
  parameter int unsigned CTRL_ADDR   = 1,
  parameter int unsigned WPD_BIT     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fault_ctl_en,
  input  logic [NUM_FAULT-1:0] fault_in_en,
  input  logic [NUM_FAULT-1:0] fault_in,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 wp_en
);
  import fsr_pkg::*;

  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] CT_A = ADDR_W'(CTRL_ADDR);

  acc_t                 acc;
  logic [NUM_FAULT-1:0] det;
  logic [NUM_FAULT-1:0] flag_vec;
  logic                 sum_clr;
  logic                 live;
  logic [DATA_W-1:0]    stat_word, ctl_word;

  assign acc.rd_stat = rd_en & (addr == ST_A);
  assign acc.wr_stat = wr_en & (addr == ST_A);
  assign acc.rd_ctl  = rd_en & (addr == CT_A);
  assign acc.wr_ctl  = wr_en & (addr == CT_A);

  assign det  = fault_in & fault_in_en & {NUM_FAULT{fault_ctl_en}};
  assign live = |det;

  for (genvar i = 0; i < NUM_FAULT; i++) begin : g_cell
    fsr_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .det     (det[i]),
      .rd_stat (acc.rd_stat),
      .wr_stat (acc.wr_stat),
      .wbit    (wdata[i]),
      .sum_clr (sum_clr),
      .flag_o  (flag_vec[i])
    );
  end

  fsr_sum_ctl #(.NUM_FAULT(NUM_FAULT)) u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .det     (det),
    .flags   (flag_vec),
    .rd_stat (acc.rd_stat),
    .wr_stat (acc.wr_stat),
    .wbit    (wdata[SUM_POS]),
    .sum_clr (sum_clr)
  );

  fsr_wp_latch u_wp (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stat (acc.rd_stat),
    .wr_stat (acc.wr_stat),
    .set_bit (wdata[WP_POS]),
    .wr_ctl  (acc.wr_ctl),
    .dis_bit (wdata[WPD_BIT]),
    .wp_o    (wp_en)
  );

  always_comb begin
    stat_word = '0;
    stat_word[NUM_FAULT-1:0] = flag_vec;
    stat_word[LIVE_POS]      = live;
    stat_word[WP_POS]        = wp_en;
    stat_word[SUM_POS]       = |flag_vec;
    ctl_word = '0;
    ctl_word[WPD_BIT]        = ~wp_en;
  end

  always_comb begin
    if (acc.rd_stat)     rdata = stat_word;
    else if (acc.rd_ctl) rdata = ctl_word;
    else                 rdata = '0;
  end
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk #(
  parameter int unsigned NUM_FAULT   = 4,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STATUS_ADDR = 0,
  parameter int unsigned CTRL_ADDR   = 1,
  parameter int unsigned WPD_BIT     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fault_ctl_en,
  input logic [NUM_FAULT-1:0] fault_in_en,
  input logic [NUM_FAULT-1:0] fault_in,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_FAULT-1:0] flags,
  input logic                 wp_en
);
  logic rd_st, wr_st, wr_ct;
  assign rd_st = rd_en && (addr == ADDR_W'(STATUS_ADDR));
  assign wr_st = wr_en && (addr == ADDR_W'(STATUS_ADDR));
  assign wr_ct = wr_en && (addr == ADDR_W'(CTRL_ADDR));

  for (genvar i = 0; i < NUM_FAULT; i++) begin : g_fl
    // R2 and R6: a gated fault always leaves its flag set
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_ctl_en && fault_in_en[i] && fault_in[i]) |=> flags[i]);
    // R3: a flag only falls after a status write
    assert_clear_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(wr_st));
  end

  assert_summary_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |-> (rdata[7] == (|rdata[3:0])));

  assert_live_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !fault_ctl_en) |-> !rdata[5]);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |-> (rdata[DATA_W-1:8] == '0 && !rdata[4]));

  assert_wp_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && wdata[6]) |=> wp_en);

  assert_wp_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wp_en) |-> $past(wr_ct && wdata[WPD_BIT]));

  assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind fault_status_reg fsr_chk #(
  .NUM_FAULT(NUM_FAULT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .STATUS_ADDR(STATUS_ADDR), .CTRL_ADDR(CTRL_ADDR), .WPD_BIT(WPD_BIT)
) u_fsr_chk (
  .clk(clk), .rst_n(rst_n), .fault_ctl_en(fault_ctl_en),
  .fault_in_en(fault_in_en), .fault_in(fault_in), .rd_en(rd_en),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .flags(flag_vec), .wp_en(wp_en)
);

// File: tb/tb_fault_status_reg.sv
module tb_fault_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_ctl_en = 1'b0;
  logic [3:0]  fault_in_en = '0;
  logic [3:0]  fault_in = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wp_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fault_status_reg dut (
    .clk(clk), .rst_n(rst_n), .fault_ctl_en(fault_ctl_en),
    .fault_in_en(fault_in_en), .fault_in(fault_in), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .wp_en(wp_en)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 idle, 1 read, 2 write
    logic [3:0]  adr;
    logic [31:0] wd;
    logic        ctl;
    logic [3:0]  en;
    logic [3:0]  fin;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 58;
  localparam vec_t VEC [NV] = '{
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd1},  // R1 reset state
    '{2'd0,4'd0,32'h0,1'b1,4'hF,4'h1,1'b0,32'h00,4'd2},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h81,4'd2},  // R2 flag0 set
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h00,4'd3},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd3},  // R3 cleared
    '{2'd0,4'd0,32'h0,1'b0,4'hF,4'hF,1'b0,32'h00,4'd2},
    '{2'd1,4'd0,32'h0,1'b0,4'hF,4'hF,1'b1,32'h00,4'd8},  // R8/R2 global off
    '{2'd0,4'd0,32'h0,1'b1,4'h0,4'hF,1'b0,32'h00,4'd2},
    '{2'd1,4'd0,32'h0,1'b1,4'h0,4'hF,1'b1,32'h00,4'd2},  // R2 lines off
    '{2'd0,4'd0,32'h0,1'b1,4'h4,4'h4,1'b0,32'h00,4'd2},
    '{2'd1,4'd0,32'h0,1'b1,4'h4,4'h4,1'b1,32'hA4,4'd8},  // R8 live
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h4,1'b0,32'h00,4'd3},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h84,4'd3},  // R3 fault present
    '{2'd0,4'd0,32'h0,1'b1,4'hF,4'h4,1'b0,32'h00,4'd4},
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h00,4'd4},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h84,4'd4},  // R4 cancelled
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h00,4'd4},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd4},  // R4 fresh read ok
    '{2'd0,4'd0,32'h0,1'b1,4'hF,4'h8,1'b0,32'h00,4'd2},
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h00,4'd3},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h88,4'd3},  // R3 no arm
    '{2'd2,4'd0,32'h8F,1'b1,4'hF,4'h0,1'b0,32'h00,4'd3},
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h00,4'd5},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h88,4'd5},  // R5 disarmed
    '{2'd0,4'd0,32'h0,1'b1,4'hF,4'h2,1'b0,32'h00,4'd2},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h8A,4'd7},  // R7 two flags
    '{2'd2,4'd0,32'h0F,1'b1,4'hF,4'h0,1'b0,32'h00,4'd7},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd7},  // R7 all cleared
    '{2'd0,4'd0,32'h0,1'b1,4'hF,4'h1,1'b0,32'h00,4'd2},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h1,1'b1,32'hA1,4'd8},  // R8 live with flag
    '{2'd2,4'd0,32'h0F,1'b1,4'hF,4'h1,1'b0,32'h00,4'd7},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h81,4'd7},  // R7 blocked
    '{2'd2,4'd0,32'h0F,1'b1,4'hF,4'h0,1'b0,32'h00,4'd7},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd7},  // R7 clear
    '{2'd0,4'd0,32'h0,1'b1,4'hF,4'h4,1'b0,32'h00,4'd2},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h84,4'd6},
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h4,1'b0,32'h00,4'd6},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h84,4'd6},  // R6 detection wins
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h00,4'd6},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd6},
    '{2'd2,4'd0,32'hFFFFFF10,1'b1,4'hF,4'h0,1'b0,32'h00,4'd9},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd9},  // R9 reserved
    '{2'd2,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h00,4'd10},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd10}, // R10 zero no effect
    '{2'd2,4'd0,32'h40,1'b1,4'hF,4'h0,1'b0,32'h00,4'd10},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h40,4'd10}, // R10 set
    '{2'd1,4'd1,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd11}, // R11 disable reads 0
    '{2'd2,4'd1,32'h4,1'b1,4'hF,4'h0,1'b0,32'h00,4'd11},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd11}, // R11 cleared
    '{2'd1,4'd1,32'h0,1'b1,4'hF,4'h0,1'b1,32'h04,4'd11}, // R11 inverse
    '{2'd2,4'd0,32'h40,1'b1,4'hF,4'h0,1'b0,32'h00,4'd11},
    '{2'd2,4'd1,32'h4,1'b1,4'hF,4'h0,1'b0,32'h00,4'd11},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h40,4'd11}, // R11 no arm
    '{2'd2,4'd1,32'h0,1'b1,4'hF,4'h0,1'b0,32'h00,4'd11},
    '{2'd2,4'd1,32'h4,1'b1,4'hF,4'h0,1'b0,32'h00,4'd11},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h40,4'd11}, // R11 disarmed
    '{2'd2,4'd1,32'h4,1'b1,4'hF,4'h0,1'b0,32'h00,4'd11},
    '{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b1,32'h00,4'd11}  // R11 cleared
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic apply(input vec_t v);
    rd_en        = (v.op == 2'd1);
    wr_en        = (v.op == 2'd2);
    addr         = v.adr;
    wdata        = v.wd;
    fault_ctl_en = v.ctl;
    fault_in_en  = v.en;
    fault_in     = v.fin;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(VEC[k]);
      #5;
      if (VEC[k].chk) check(int'(VEC[k].req), rdata, VEC[k].exp);
    end

    // R12: flag set, no read strobe -> rdata stays 0
    @(negedge clk);
    apply('{2'd0,4'd0,32'h0,1'b1,4'hF,4'h2,1'b0,32'h0,4'd12});
    @(negedge clk);
    apply('{2'd0,4'd0,32'hFFFFFFFF,1'b1,4'hF,4'h0,1'b0,32'h0,4'd12});
    #5 check(12, rdata, 32'h0);

    // R10: write-protect visible on its port
    @(negedge clk);
    apply('{2'd2,4'd0,32'h42,1'b1,4'hF,4'h0,1'b0,32'h0,4'd10});
    @(negedge clk);
    apply('{2'd0,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h0,4'd10});
    #5 check(10, {31'b0, wp_en}, 32'h1);

    // R1: reset clears flag and protect
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply('{2'd1,4'd0,32'h0,1'b1,4'hF,4'h0,1'b0,32'h0,4'd1});
    #5;
    check(1, rdata, 32'h0);
    check(1, {31'b0, wp_en}, 32'h0);
    @(negedge clk);
    apply('{2'd0,4'd0,32'h0,1'b0,4'h0,4'h0,1'b0,32'h0,4'd1});
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule